// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between a host register port and a small serial EEPROM that uses a three-wire protocol. The three wires are a chip select, a serial clock, and a data line in each direction. The host writes one byte into a command register. That byte holds a two-bit operation code and a six-bit word address. The controller then runs the whole serial transaction on its own. While it does so it raises a busy flag, which the host polls in bit 15 of the same register.

A separate 16-bit data register carries the word in both directions:
- It supplies the word for a write.
- It receives the word that a read returns.

Write and erase operations end with a ready handshake. The controller drops the select line for one half clock period and then raises it again. It then waits until the device pulls its output line high. If that never happens, it waits until a timeout counter runs out.

The serial clock half-period is set at run time by a divider input.

Top module: `ee_cmd_ctrl`

## Requirements
- R1: After reset, the command readback and the data register read zero, and the select, serial clock and serial data-out lines are low.
- R2: The command readback carries the busy flag in bit 15, zeros in bits 14:8, and the last accepted command byte in bits 7:0. Busy reads 1 from the cycle after a command write is accepted until the operation ends.
- R3: Every frame opens with a start bit of 1. The start bit is followed by the opcode (command bits 7:6) and then the address (command bits 5:0), all sent most significant bit first. The data-out line changes only while the serial clock is low, and the device samples it on the rising edge.
- R4: While select is high and the frame is shifting, each low and each high phase of the serial clock lasts div_i+1 system clock cycles. A 9-bit frame therefore keeps busy for 18*(div_i+1) cycles and a 25-bit frame for 50*(div_i+1) cycles.
- R5: Opcode 2 (read) adds 16 clock periods after the address. The data-in line is sampled at the end of each of those high phases, most significant bit first. The 16-bit result is in the data register when busy clears.
- R6: Opcode 1 (write) adds 16 clock periods after the address. During them it sends the data register contents, most significant bit first.
- R7: After a write (opcode 1) or an erase (opcode 3) frame, select stays low for div_i+1 cycles and then rises. Busy then holds until the data-in line reads 1, after which select drops and busy clears.
- R8: If the data-in line stays 0 during the ready wait, busy clears after TIMEOUT cycles of waiting. An erase then keeps busy for exactly 19*(div_i+1)+TIMEOUT cycles.
- R9: Opcode 0 is the extended group. It sends only the 9-bit frame and does no ready wait; the value 0x30 is write-enable and 0x00 is write-disable.
- R10: A command write or a data register write that arrives while busy is set is ignored. It changes neither the readback, the frame on the wire nor the data register.
- R11: While idle, select, serial clock and serial data-out stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 8 | Command byte: opcode in 7:6, address in 5:0 |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 16 | Data register write value |
| cmd_rdata_o | output | 16 | Command readback: busy in bit 15, last command in 7:0 |
| data_o | output | 16 | Data register contents |
| ee_cs_o | output | 1 | EEPROM select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data and ready from the EEPROM |

## Verification
The bench builds the block with DIV_W=3 and TIMEOUT=40. A 3-bit divider lets every divider setting from 0 to 3 be swept over all 64 addresses, so each read is compared against an arithmetic pattern at every clock rate. A short timeout makes the ready-wait expiry reachable, and its exact busy length can be checked against 19*(div_i+1)+TIMEOUT. The bench's device model also honours write-enable and write-disable, so write, erase and read-back sequences check the frame contents end to end.

// File: rtl/ee_ctl_pkg.sv
package ee_ctl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_WAIT} ee_state_e;

  localparam logic [1:0] OP_EXT   = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_ERASE = 2'd3;

  localparam int HDR_BITS  = 9;
  localparam int WORD_BITS = 16;
  localparam int FRAME_W   = HDR_BITS + WORD_BITS;
endpackage

// File: rtl/ee_sk_div.sv
module ee_sk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R4: with a non-zero divider, two ticks are never back to back
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/ee_shifter.sv
module ee_shifter #(
  parameter int FRAME_W   = 25,
  parameter int WORD_BITS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_W-1:0]   load_val_i,
  input  logic                 shift_i,
  input  logic                 sin_i,
  output logic                 msb_o,
  output logic [WORD_BITS-2:0] rx_o
);
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= load_val_i;
    else if (shift_i) sreg_q <= {sreg_q[FRAME_W-2:0], sin_i};
  end

  assign msb_o = sreg_q[FRAME_W-1];
  assign rx_o  = sreg_q[WORD_BITS-2:0];
endmodule

// File: rtl/ee_ready_wait.sv
module ee_ready_wait #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic ready_i,
  output logic done_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = active_i && (ready_i || cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= '0;
    else if (active_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R8: the wait never runs past its limit
  a_r8_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/ee_cmd_ctrl.sv
module ee_cmd_ctrl
  import ee_ctl_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_we_i,
  input  logic [7:0]       cmd_wdata_i,
  input  logic             data_we_i,
  input  logic [15:0]      data_wdata_i,
  output logic [15:0]      cmd_rdata_o,
  output logic [15:0]      data_o,
  output logic             ee_cs_o,
  output logic             ee_sk_o,
  output logic             ee_di_o,
  input  logic             ee_do_i
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(HDR_BITS);

  ee_state_e               state_q;
  logic [7:0]              cmd_q;
  logic [WORD_BITS-1:0]    data_q;
  logic                    cs_q, sk_q;
  logic [CNT_W-1:0]        bits_q;

  logic                    busy, accept, tick, shift, msb, wait_done;
  logic [WORD_BITS-2:0]    rx;
  logic [1:0]              new_op, cur_op;
  logic                    need_wait;
  logic [FRAME_W-1:0]      load_val;

  assign busy      = (state_q != ST_IDLE);
  assign accept    = cmd_we_i && !busy;
  assign new_op    = cmd_wdata_i[7:6];
  assign cur_op    = cmd_q[7:6];
  assign need_wait = (cur_op == OP_WRITE) || (cur_op == OP_ERASE);
  assign shift     = (state_q == ST_SHIFT) && tick && sk_q;
  assign load_val  = {1'b1, cmd_wdata_i, (new_op == OP_WRITE) ? data_q : {WORD_BITS{1'b0}}};

  ee_sk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ((state_q == ST_SHIFT) || (state_q == ST_GAP)),
    .div_i  (div_i),
    .tick_o (tick)
  );

  ee_shifter #(.FRAME_W(FRAME_W), .WORD_BITS(WORD_BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (load_val),
    .shift_i    (shift),
    .sin_i      (ee_do_i),
    .msb_o      (msb),
    .rx_o       (rx)
  );

  ee_ready_wait #(.TIMEOUT(TIMEOUT)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  ((state_q == ST_GAP) && tick),
    .active_i (state_q == ST_WAIT),
    .ready_i  (ee_do_i),
    .done_o   (wait_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      data_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      bits_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (data_we_i) data_q <= data_wdata_i;
          if (accept) begin
            cmd_q   <= cmd_wdata_i;
            cs_q    <= 1'b1;
            sk_q    <= 1'b0;
            bits_q  <= (new_op == OP_WRITE || new_op == OP_READ) ? LEN_LONG : LEN_SHORT;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
            end else begin
              sk_q   <= 1'b0;
              bits_q <= bits_q - 1'b1;
              if (bits_q == CNT_W'(1)) begin
                cs_q    <= 1'b0;
                state_q <= need_wait ? ST_GAP : ST_IDLE;
                if (cur_op == OP_READ) data_q <= {rx, ee_do_i};
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            cs_q    <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            cs_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_rdata_o = {busy, 7'b0, cmd_q};
  assign data_o      = data_q;
  assign ee_cs_o     = cs_q;
  assign ee_sk_o     = sk_q;
  assign ee_di_o     = (state_q == ST_SHIFT) && msb;

  // R11: lines quiet while idle
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));
  // R2: busy visible right after acceptance
  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cmd_rdata_o[15]);
  // R3: start bit leads every frame
  a_r3_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (ee_cs_o && ee_di_o));
  // R3: data-out steady while the serial clock is high
  a_r3_di_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));
  // R10: command held for the whole operation
  a_r10_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(cmd_rdata_o[7:0]));
  // R7: select low through the gap
  a_r7_gap_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> !ee_cs_o);
endmodule

// File: tb/ee_cmd_ctrl_test.sv
module ee_cmd_ctrl_test;
  localparam int DIV_W = 3;
  localparam int TMO   = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [DIV_W-1:0] div;
  logic        cmd_we = 1'b0, data_we = 1'b0;
  logic [7:0]  cmd_wd = '0;
  logic [15:0] data_wd = '0;
  logic [15:0] cmd_rd, data_rd;
  logic        cs, sk, di, do_r;

  ee_cmd_ctrl #(.DIV_W(DIV_W), .TIMEOUT(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .data_we_i(data_we), .data_wdata_i(data_wd),
    .cmd_rdata_o(cmd_rd), .data_o(data_rd),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_r)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  function automatic logic [15:0] init_val(int a);
    return 16'h5A00 ^ 16'(a * 263);
  endfunction

  // device model
  logic [15:0] mem [64];
  logic [8:0]  hdr, last_hdr;
  logic [15:0] wd, last_wd;
  int  bitc = 0, last_bits = 0, frames = 0, prog_cnt = 0, prog_delay = 8, run = 0, r4_bad = 0;
  logic wen = 1'b0, cs_p = 1'b0, sk_p = 1'b0;

  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);

  always @(negedge clk) begin
    if (prog_cnt > 0) prog_cnt--;
    if (cs && !cs_p) begin bitc = 0; hdr = '0; wd = '0; end
    // R4 phase-length monitor
    if (cs) begin
      if (!cs_p) run = 1;
      else if (sk != sk_p) begin
        if (run != int'(div) + 1) r4_bad++;
        run = 1;
      end else run++;
    end
    if (cs && sk && !sk_p) begin
      if (bitc < 9) hdr = {hdr[7:0], di};
      else if (bitc < 25) wd = {wd[14:0], di};
      bitc++;
    end
    if (!cs && cs_p && bitc > 0) begin
      last_hdr = hdr; last_wd = wd; last_bits = bitc; frames++;
      case (hdr[7:6])
        2'd1: if (bitc == 25) begin
                if (wen) mem[hdr[5:0]] = wd;
                prog_cnt = prog_delay;
              end
        2'd3: begin
                if (wen) mem[hdr[5:0]] = 16'hFFFF;
                prog_cnt = prog_delay;
              end
        2'd0: if (hdr[5:4] == 2'b11) wen = 1'b1;
              else if (hdr[5:4] == 2'b00) wen = 1'b0;
        default: ;
      endcase
      bitc = 0;
    end
    if (cs && hdr[8] && hdr[7:6] == 2'd2 && bitc >= 10 && bitc <= 25)
      do_r = mem[hdr[5:0]][25 - bitc];
    else
      do_r = cs && bitc == 0 && prog_cnt == 0;
    cs_p = cs; sk_p = sk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic run_cmd(input logic [7:0] c, output int busy_n);
    @(negedge clk); cmd_we = 1'b1; cmd_wd = c;
    @(negedge clk); cmd_we = 1'b0;
    busy_n = 0;
    while (cmd_rd[15]) begin busy_n++; @(negedge clk); end
    #1;
  endtask

  task automatic load_data(input logic [15:0] v);
    @(negedge clk); data_we = 1'b1; data_wd = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    int n, f0, d1;
    logic [15:0] v;
    div = 3'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_rdata", cmd_rd, 16'h0);
    chk("R1 data", data_rd, 16'h0);
    chk("R1 lines", {cs, sk, di}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cmd_rd, data_rd, cs, sk, di}, '0);

    load_data(16'h1234);
    chk("R10 data load idle", data_rd, 16'h1234);

    // R5/R3/R4 read sweep over all dividers and addresses
    for (int d = 0; d < 4; d++) begin
      div = 3'(d);
      for (int a = 0; a < 64; a++) begin
        run_cmd({2'b10, 6'(a)}, n);
        chk("R5 read data", data_rd, init_val(a));
        chk("R3 read header", last_hdr, {1'b1, 2'b10, 6'(a)});
        chk("R4 read busy", n, 50 * (d + 1));
        chk("R2 readback", cmd_rd, {8'h00, 2'b10, 6'(a)});
      end
    end
    chk("R4 phase lengths", r4_bad, 0);

    div = 3'd2; d1 = 3;
    // R9 write-disable, then write must not land
    run_cmd(8'h00, n);
    chk("R9 ewds bits", last_bits, 9);
    chk("R9 ewds busy", n, 18 * d1);
    load_data(16'hBEEF);
    run_cmd({2'b01, 6'd5}, n);
    chk("R6 write data on wire", last_wd, 16'hBEEF);
    chk("R7 ready seen", prog_cnt, 0);
    chk("R7 waited", n > 50 * d1 + d1, 1);
    run_cmd({2'b10, 6'd5}, n);
    chk("R5 unwritten word", data_rd, init_val(5));

    // R9 write-enable 0x30
    run_cmd(8'h30, n);
    chk("R9 ewen header", last_hdr, 9'h130);
    chk("R9 ewen bits", last_bits, 9);
    chk("R9 ewen busy", n, 18 * d1);

    // R6/R7 writes and read-back
    foreach (mem[i]) if (i == 0 || i == 17 || i == 42 || i == 63) begin
      v = 16'(i * 16'h0301) ^ 16'hC3C3;
      load_data(v);
      run_cmd({2'b01, 6'(i)}, n);
      chk("R6 write bits", last_bits, 25);
      chk("R6 write word", last_wd, v);
      chk("R7 write ready", prog_cnt, 0);
      run_cmd({2'b10, 6'(i)}, n);
      chk("R6 read back", data_rd, v);
    end

    // R7 erase with ready
    run_cmd({2'b11, 6'd17}, n);
    chk("R7 erase header", last_hdr, {1'b1, 2'b11, 6'd17});
    chk("R7 erase ready", prog_cnt, 0);
    run_cmd({2'b10, 6'd17}, n);
    chk("R7 erased word", data_rd, 16'hFFFF);

    // R8 timeout: device never ready
    for (int d = 0; d < 4; d++) begin
      div = 3'(d);
      prog_delay = 1000;
      run_cmd({2'b11, 6'd42}, n);
      chk("R8 timeout busy", n, 19 * (d + 1) + TMO);
      chk("R8 cleared before ready", prog_cnt > 0, 1);
      prog_delay = 8;
      repeat (1000) @(negedge clk);
    end

    // R10 command and data writes while busy
    div = 3'd1;
    load_data(16'h0F0F);
    f0 = frames;
    run_cmd(8'h30, n);
    @(negedge clk); cmd_we = 1'b1; cmd_wd = {2'b10, 6'd3};
    @(negedge clk); cmd_we = 1'b0;
    repeat (4) @(negedge clk);
    cmd_we = 1'b1; cmd_wd = 8'hC5; data_we = 1'b1; data_wd = 16'hAAAA;
    @(negedge clk); cmd_we = 1'b0; data_we = 1'b0;
    chk("R10 readback kept", cmd_rd, {8'h80, 2'b10, 6'd3});
    while (cmd_rd[15]) @(negedge clk);
    #1;
    chk("R10 read result", data_rd, init_val(3));
    chk("R10 header kept", last_hdr, {1'b1, 2'b10, 6'd3});
    chk("R10 one frame each", frames - f0, 2);
    // data write during an opcode-0 op
    @(negedge clk); cmd_we = 1'b1; cmd_wd = 8'h30;
    @(negedge clk); cmd_we = 1'b0; data_we = 1'b1; data_wd = 16'h5555;
    @(negedge clk); data_we = 1'b0;
    while (cmd_rd[15]) @(negedge clk);
    chk("R10 data write ignored", data_rd, init_val(3));

    @(negedge clk);
    chk("R11 idle lines", {cs, sk, di}, 3'b000);
    report();
  end
endmodule